// File: doc/BRIEF.md
# Multi-channel DMA cycle sequencer

This block lets several DMA channels share one word-transfer engine. Each channel holds a control word with four parts: a 3-bit cycle code, a burst exponent `R`, a count of transfers still to do, and source and destination word addresses. The engine moves one word at a time. It reads the source, writes that word to the destination, then advances both addresses and lowers the count by one. Once a channel wins the engine, it keeps it for a burst of `2^R` transfers, or for fewer if fewer remain. After the burst the block arbitrates again. Arbitration uses fixed priority, and the lowest channel index wins.

Two cycle kinds are carried out. A basic cycle takes part in an arbitration only while its request line is high at that arbitration point. It therefore needs a fresh request for every burst. An auto-request cycle is armed by its first grant, and after that it competes at every arbitration point until its count is used up. When the count reaches zero, the block rewrites the channel's code to invalid and pulses that channel's done line for one clock. All codes other than invalid, basic and auto-request are rejected: such a channel raises an error flag and is never granted.

Software or a controller loads a channel through a plain one-cycle write strobe. A write aimed at the channel that currently owns the engine is dropped. Memory traffic uses three valid/ready channels: read request, read data and write. A transfer moves on only when both sides of a handshake are high at a clock edge. While a valid is high and its ready is low, the block holds that valid and its payload unchanged, so a slow memory simply stalls the engine.

Top module: `dma_cycle_seq`

## Requirements
- R1: The cycle code is 3 bits: 3'b000 invalid, 3'b001 basic, 3'b010 auto-request, and 3'b011 through 3'b111 unsupported. `type_o[3c+2:3c]` reports channel c's stored code, which is loaded by a configuration write.
- R2: A channel whose code is invalid never gets a transfer.
- R3: A granted channel performs min(2^R, remaining) transfers before the next arbitration. No other channel transfers during that burst, even one with higher priority.
- R4: At an arbitration point, the lowest-index eligible channel wins. A basic channel is eligible when its request is high and its count is nonzero. An auto channel is eligible when its count is nonzero and it is either requesting or armed.
- R5: After a burst of a basic cycle with transfers still left, the channel continues only if its request is high at a later arbitration point.
- R6: A single request to an auto-request cycle completes the whole cycle without further requests.
- R7: A transfer has three steps: a read request with `rd_addr_o` = source, then read data, then a write with `wr_addr_o` = destination and `wr_data_o` = the word read. Source and destination then advance by 1 and the count drops by 1. `xfer_ch_o` names the active channel.
- R8: On a channel's final write, its code becomes 3'b000 and `done_o[c]` is high for exactly one cycle, starting the cycle after that write handshake.
- R9: A channel holding an unsupported code has `err_o[c]` high and gets no transfers.
- R10: While `rd_valid_o` or `wr_valid_o` is high and the matching ready is low, the valid stays high and its address and data stay stable.
- R11: After reset, every code is invalid, and all valids, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Per-channel request levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel to configure |
| cfg_type_i | input | 3 | Cycle code to load |
| cfg_rpow_i | input | RP_W | Burst exponent R |
| cfg_count_i | input | CNT_W | Transfer count |
| cfg_src_i | input | ADDR_W | Source word address |
| cfg_dst_i | input | ADDR_W | Destination word address |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request ready |
| rd_addr_o | output | ADDR_W | Read address |
| rdat_valid_i | input | 1 | Read data valid |
| rdat_ready_o | output | 1 | Read data ready |
| rdat_i | input | DATA_W | Read data |
| wr_valid_o | output | 1 | Write valid |
| wr_ready_i | input | 1 | Write ready |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| xfer_ch_o | output | CH_W | Channel owning the current transfer |
| done_o | output | NCH | One-cycle completion pulse per channel |
| err_o | output | NCH | Unsupported code held per channel |
| type_o | output | 3*NCH | Stored cycle code per channel |

## Verification
The bench uses the default parameters: four channels, a 10-bit count and a 4-bit exponent. It draws exponents from 0 to 3 and counts from 1 to 20, so some bursts end on the `2^R` limit and others end on a count that runs out part-way through a burst. With four channels competing, a low-priority channel can hold a long burst while a higher one waits. The random ready and data-valid timing stalls every handshake step, and the random codes cover the unsupported values mixed in with live channels.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam logic [2:0] CYC_INVALID = 3'b000;
  localparam logic [2:0] CYC_BASIC   = 3'b001;
  localparam logic [2:0] CYC_AUTO    = 3'b010;

  typedef enum logic [1:0] {
    ST_ARB  = 2'd0,
    ST_RREQ = 2'd1,
    ST_RRSP = 2'd2,
    ST_WR   = 2'd3
  } eng_st_t;
endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int RP_W   = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_type,
  input  logic [RP_W-1:0]   cfg_rpow,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic              req,
  input  logic              owned,
  input  logic              start,
  input  logic              commit,
  output logic              elig,
  output logic [2:0]        cyc_type,
  output logic [RP_W-1:0]   rpow,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              done,
  output logic              err
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_type <= CYC_INVALID;
      rpow     <= '0;
      count    <= '0;
      src      <= '0;
      dst      <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (commit) begin
        count <= count - CNT_W'(1);
        src   <= src + ADDR_W'(1);
        dst   <= dst + ADDR_W'(1);
        if (count == CNT_W'(1)) begin
          cyc_type <= CYC_INVALID;
          armed    <= 1'b0;
          done     <= 1'b1;
        end
      end else if (cfg_we && !owned) begin
        cyc_type <= cfg_type;
        rpow     <= cfg_rpow;
        count    <= cfg_count;
        src      <= cfg_src;
        dst      <= cfg_dst;
        armed    <= 1'b0;
      end
      if (start && cyc_type == CYC_AUTO) armed <= 1'b1;
    end
  end

  assign elig = (count != '0) &&
                ((cyc_type == CYC_BASIC && req) ||
                 (cyc_type == CYC_AUTO && (req || armed)));
  assign err  = cyc_type[2] | (cyc_type[1] & cyc_type[0]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_type == CYC_INVALID);
  assert_owned_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> (cyc_type == CYC_BASIC || cyc_type == CYC_AUTO));
  assert_commit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> count != '0);
endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
  import dma_seq_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int CNT_W  = 10,
  parameter int RP_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CH_W-1:0]   pick,
  input  logic [RP_W-1:0]   sel_rpow,
  input  logic [CNT_W-1:0]  sel_count,
  input  logic [ADDR_W-1:0] sel_src,
  input  logic [ADDR_W-1:0] sel_dst,
  output logic [CH_W-1:0]   cur,
  output logic              busy,
  output logic              start,
  output logic              commit,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rdat_valid,
  output logic              rdat_ready,
  input  logic [DATA_W-1:0] rdat,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  eng_st_t            st;
  logic [CNT_W-1:0]   beat;
  logic [CNT_W-1:0]   lim;
  logic [DATA_W-1:0]  data_q;
  logic               end_burst;

  always_comb begin
    if (int'(sel_rpow) >= CNT_W) lim = '1;
    else lim = (CNT_W'(1) << sel_rpow) - CNT_W'(1);
    end_burst = (sel_count == CNT_W'(1)) || (beat == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_ARB;
      cur    <= '0;
      beat   <= '0;
      data_q <= '0;
    end else begin
      unique case (st)
        ST_ARB: if (any) begin
          cur  <= pick;
          beat <= '0;
          st   <= ST_RREQ;
        end
        ST_RREQ: if (rd_ready) st <= ST_RRSP;
        ST_RRSP: if (rdat_valid) begin
          data_q <= rdat;
          st     <= ST_WR;
        end
        ST_WR: if (wr_ready) begin
          if (end_burst) st <= ST_ARB;
          else begin
            beat <= beat + CNT_W'(1);
            st   <= ST_RREQ;
          end
        end
        default: st <= ST_ARB;
      endcase
    end
  end

  assign busy       = (st != ST_ARB);
  assign start      = (st == ST_ARB) && any;
  assign rd_valid   = (st == ST_RREQ);
  assign rdat_ready = (st == ST_RRSP);
  assign wr_valid   = (st == ST_WR);
  assign commit     = wr_valid && wr_ready;
  assign rd_addr    = sel_src;
  assign wr_addr    = sel_dst;
  assign wr_data    = data_q;

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 10,
  parameter int RP_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [2:0]        cfg_type_i,
  input  logic [RP_W-1:0]   cfg_rpow_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rdat_valid_i,
  output logic              rdat_ready_o,
  input  logic [DATA_W-1:0] rdat_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CH_W-1:0]   xfer_ch_o,
  output logic [NCH-1:0]    done_o,
  output logic [NCH-1:0]    err_o,
  output logic [3*NCH-1:0]  type_o
);
  logic [NCH-1:0]    elig, own, start_v, commit_v;
  logic [2:0]        typ [NCH];
  logic [RP_W-1:0]   rp  [NCH];
  logic [CNT_W-1:0]  cnt [NCH];
  logic [ADDR_W-1:0] src [NCH];
  logic [ADDR_W-1:0] dst [NCH];
  logic              busy, start, commit, any;
  logic [CH_W-1:0]   pick, cur;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_seq_chan #(.CNT_W(CNT_W), .RP_W(RP_W), .ADDR_W(ADDR_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we_i && (cfg_ch_i == CH_W'(c))),
      .cfg_type (cfg_type_i),
      .cfg_rpow (cfg_rpow_i),
      .cfg_count(cfg_count_i),
      .cfg_src  (cfg_src_i),
      .cfg_dst  (cfg_dst_i),
      .req      (req_i[c]),
      .owned    (own[c]),
      .start    (start_v[c]),
      .commit   (commit_v[c]),
      .elig     (elig[c]),
      .cyc_type (typ[c]),
      .rpow     (rp[c]),
      .count    (cnt[c]),
      .src      (src[c]),
      .dst      (dst[c]),
      .done     (done_o[c]),
      .err      (err_o[c])
    );
    assign own[c]          = busy && (cur == CH_W'(c));
    assign start_v[c]      = start && (pick == CH_W'(c));
    assign commit_v[c]     = commit && (cur == CH_W'(c));
    assign type_o[3*c +: 3] = typ[c];
  end

  dma_seq_arb #(.N(NCH), .IDX_W(CH_W)) u_arb (
    .elig(elig),
    .any (any),
    .idx (pick)
  );

  dma_seq_engine #(
    .CH_W(CH_W), .CNT_W(CNT_W), .RP_W(RP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .any       (any),
    .pick      (pick),
    .sel_rpow  (rp[cur]),
    .sel_count (cnt[cur]),
    .sel_src   (src[cur]),
    .sel_dst   (dst[cur]),
    .cur       (cur),
    .busy      (busy),
    .start     (start),
    .commit    (commit),
    .rd_valid  (rd_valid_o),
    .rd_ready  (rd_ready_i),
    .rd_addr   (rd_addr_o),
    .rdat_valid(rdat_valid_i),
    .rdat_ready(rdat_ready_o),
    .rdat      (rdat_i),
    .wr_valid  (wr_valid_o),
    .wr_ready  (wr_ready_i),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o)
  );

  assign xfer_ch_o = cur;

  assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));
  assert_xfer_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o || wr_valid_o) |-> !err_o[cur]);
endmodule

// File: tb/tb_dma_cycle_seq.sv
module tb_dma_cycle_seq;
  localparam int NCH = 4, CNT_W = 10, RP_W = 4, ADDR_W = 16, DATA_W = 32, CH_W = 2;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] req_drv = '0, req_at_edge = '0;
  logic cfg_we = 0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic [2:0] cfg_type = '0;
  logic [RP_W-1:0] cfg_rpow = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [ADDR_W-1:0] cfg_src = '0, cfg_dst = '0;
  logic rd_valid_o, rd_ready_i = 0, rdat_valid_i = 0, rdat_ready_o, wr_valid_o, wr_ready_i = 0;
  logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
  logic [DATA_W-1:0] rdat_i = '0, wr_data_o;
  logic [CH_W-1:0] xfer_ch_o;
  logic [NCH-1:0] done_o, err_o;
  logic [3*NCH-1:0] type_o;

  always #5 clk = ~clk;
  always @(posedge clk) req_at_edge <= req_drv;

  dma_cycle_seq #(.NCH(NCH), .CNT_W(CNT_W), .RP_W(RP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_drv), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_type_i(cfg_type), .cfg_rpow_i(cfg_rpow), .cfg_count_i(cfg_count),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_addr_o(rd_addr_o), .rdat_valid_i(rdat_valid_i), .rdat_ready_o(rdat_ready_o),
    .rdat_i(rdat_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .xfer_ch_o(xfer_ch_o), .done_o(done_o), .err_o(err_o), .type_o(type_o));

  // bench model
  int nchk = 0, nfail = 0, cyc = 0;
  int m_type [NCH], m_rp [NCH], m_cnt [NCH];
  logic [ADDR_W-1:0] m_src [NCH], m_dst [NCH];
  bit m_arm [NCH];
  int wr_cnt [NCH], done_cnt [NCH];
  int cur_m = 0, beats = 0, order_snap = -1;
  bit new_burst = 1, run_mon = 0, rd_pend = 0, snap_en = 0;
  logic [DATA_W-1:0] rd_exp = '0;
  logic [NCH-1:0] exp_done = '0;
  bit prev_rd_stall = 0, prev_wr_stall = 0;
  logic [ADDR_W-1:0] prev_rd_addr = '0, prev_wr_addr = '0;
  logic [DATA_W-1:0] prev_wr_data = '0;

  function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic int pick_m(input logic [NCH-1:0] rq);
    for (int i = 0; i < NCH; i++)
      if (m_cnt[i] != 0 && ((m_type[i] == 1 && rq[i]) || (m_type[i] == 2 && (rq[i] || m_arm[i]))))
        return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit rv, rr, wr;
    int p;
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
    if (run_mon) begin
      chk(done_o == exp_done, "R8 done pulse", done_o, exp_done);
      for (int i = 0; i < NCH; i++) if (done_o[i]) done_cnt[i]++;
      exp_done = '0;
      // R10 back-pressure hold
      if (prev_rd_stall) chk(rd_valid_o && rd_addr_o == prev_rd_addr, "R10 read held", rd_addr_o, prev_rd_addr);
      if (prev_wr_stall) chk(wr_valid_o && wr_addr_o == prev_wr_addr && wr_data_o == prev_wr_data,
                             "R10 write held", wr_data_o, prev_wr_data);
      // R4 arbitration (R2: invalid channels never picked by model)
      if (rd_valid_o && new_burst) begin
        p = pick_m(req_at_edge);
        chk(p >= 0 && int'(xfer_ch_o) == p, "R4 grant", xfer_ch_o, p);
        cur_m = int'(xfer_ch_o);
        beats = 0;
        if (m_type[cur_m] == 2) m_arm[cur_m] = 1;
        new_burst = 0;
      end
      rv = rd_pend && ($urandom % 4 != 0);
      rdat_valid_i = rv;
      rdat_i = rd_exp;
      if (rv && rdat_ready_o) rd_pend = 0;
      rr = ($urandom % 10) < 7;
      rd_ready_i = rr;
      if (rd_valid_o && rr) begin
        chk(int'(xfer_ch_o) == cur_m, "R3 read channel", xfer_ch_o, cur_m);
        chk(rd_addr_o == m_src[cur_m], "R7 read address", rd_addr_o, m_src[cur_m]);
        rd_pend = 1;
        rd_exp = memfn(rd_addr_o);
      end
      wr = ($urandom % 10) < 6;
      wr_ready_i = wr;
      if (wr_valid_o && wr) begin
        chk(int'(xfer_ch_o) == cur_m, "R3 write channel", xfer_ch_o, cur_m);
        chk(wr_addr_o == m_dst[cur_m], "R7 write address", wr_addr_o, m_dst[cur_m]);
        chk(wr_data_o == memfn(m_src[cur_m]), "R7 write data", wr_data_o, memfn(m_src[cur_m]));
        if (snap_en && cur_m == 0 && wr_cnt[0] == 0) order_snap = wr_cnt[3];
        wr_cnt[cur_m]++;
        m_cnt[cur_m]--; m_src[cur_m]++; m_dst[cur_m]++; beats++;
        if (m_cnt[cur_m] == 0) begin
          m_type[cur_m] = 0; m_arm[cur_m] = 0;
          exp_done[cur_m] = 1'b1; new_burst = 1;
        end else if (beats == (1 << m_rp[cur_m])) new_burst = 1;
      end
      prev_rd_stall = rd_valid_o && !rr; prev_rd_addr = rd_addr_o;
      prev_wr_stall = wr_valid_o && !wr; prev_wr_addr = wr_addr_o; prev_wr_data = wr_data_o;
    end
  end

  task automatic cfg(input int ch, input int t, input int r, input int n,
                     input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
    @(posedge clk); #2;
    cfg_we = 1; cfg_ch = CH_W'(ch); cfg_type = 3'(t); cfg_rpow = RP_W'(r);
    cfg_count = CNT_W'(n); cfg_src = s; cfg_dst = d;
    m_type[ch] = t; m_rp[ch] = r; m_cnt[ch] = n; m_src[ch] = s; m_dst[ch] = d; m_arm[ch] = 0;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic set_req(input logic [NCH-1:0] v);
    @(posedge clk); #2;
    req_drv = v;
  endtask

  task automatic wait_idle();
    int quiet = 0, lim = 0;
    while (quiet < 20 && lim < 6000) begin
      @(negedge clk); #1;
      lim++;
      if (!rd_valid_o && !wr_valid_o && !rd_pend && pick_m(req_drv) < 0) quiet++;
      else quiet = 0;
    end
    chk(quiet >= 20, "R6 engine settles", lim, 6000);
  endtask

  task automatic clr_counts();
    for (int i = 0; i < NCH; i++) begin wr_cnt[i] = 0; done_cnt[i] = 0; end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin
      m_type[i] = 0; m_rp[i] = 0; m_cnt[i] = 0; m_src[i] = '0; m_dst[i] = '0; m_arm[i] = 0;
    end
    clr_counts();
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!rd_valid_o && !wr_valid_o, "R11 valids low", {rd_valid_o, wr_valid_o}, 0);
    chk(done_o == '0 && err_o == '0, "R11 done/err low", {done_o, err_o}, 0);
    chk(type_o == '0, "R11 codes invalid", type_o, 0);
    run_mon = 1;

    // R6: one pulse runs an auto cycle to the end, bursts 2,2,1
    cfg(2, 2, 1, 5, 16'h0100, 16'h0800);
    set_req(4'b0100); set_req(4'b0000);
    wait_idle();
    chk(wr_cnt[2] == 5, "R6 auto transfers", wr_cnt[2], 5);
    chk(done_cnt[2] == 1, "R8 auto done count", done_cnt[2], 1);
    chk(type_o[8:6] == 3'b000, "R8 auto code invalid", type_o[8:6], 0);

    // R5: basic needs a fresh request per burst
    clr_counts();
    cfg(1, 1, 2, 6, 16'h0200, 16'h0900);
    set_req(4'b0010); set_req(4'b0000);
    wait_idle();
    chk(wr_cnt[1] == 4, "R5 basic stops after burst", wr_cnt[1], 4);
    chk(type_o[5:3] == 3'b001 && done_cnt[1] == 0, "R5 basic still live", type_o[5:3], 1);
    set_req(4'b0010); set_req(4'b0000);
    wait_idle();
    chk(wr_cnt[1] == 6, "R5 basic resumes", wr_cnt[1], 6);
    chk(done_cnt[1] == 1 && type_o[5:3] == 3'b000, "R8 basic completes", type_o[5:3], 0);

    // R9 / R1: unsupported codes
    clr_counts();
    cfg(0, 3, 0, 3, 16'h0300, 16'h0A00);
    cfg(1, 6, 0, 3, 16'h0310, 16'h0A10);
    set_req(4'b0011);
    repeat (50) @(posedge clk);
    chk(err_o == 4'b0011, "R9 error flags", err_o, 4'b0011);
    chk(wr_cnt[0] == 0 && wr_cnt[1] == 0, "R9 no transfers", wr_cnt[0] + wr_cnt[1], 0);
    chk(type_o[2:0] == 3'b011 && type_o[5:3] == 3'b110, "R1 codes reported", type_o[5:0], 6'o63);
    set_req(4'b0000);

    // R2: invalid code with request held
    cfg(3, 0, 0, 5, 16'h0400, 16'h0B00);
    set_req(4'b1000);
    repeat (40) @(posedge clk);
    chk(wr_cnt[3] == 0, "R2 invalid not granted", wr_cnt[3], 0);
    set_req(4'b0000);
    cfg(0, 0, 0, 0, 16'h0, 16'h0);
    cfg(1, 0, 0, 0, 16'h0, 16'h0);
    wait_idle();

    // R3: low-priority burst of 8 locks out channel 0
    clr_counts();
    cfg(3, 2, 3, 12, 16'h0500, 16'h0C00);
    cfg(0, 1, 0, 4, 16'h0600, 16'h0D00);
    snap_en = 1;
    set_req(4'b1000); set_req(4'b0000);
    repeat (3) @(posedge clk);
    set_req(4'b0001);
    repeat (150) @(posedge clk);
    set_req(4'b0000);
    wait_idle();
    snap_en = 0;
    chk(order_snap == 8, "R3 burst not pre-empted", order_snap, 8);
    chk(wr_cnt[0] == 4 && wr_cnt[3] == 12, "R4 both cycles finish", wr_cnt[0] * 100 + wr_cnt[3], 412);

    // random rounds
    for (int rnd = 0; rnd < 8; rnd++) begin
      for (int c = 0; c < NCH; c++) begin
        int rsel, t;
        rsel = $urandom % 8;
        t = (rsel < 3) ? 1 : (rsel < 6) ? 2 : (rsel == 6) ? 0 : 3 + int'($urandom % 5);
        cfg(c, t, int'($urandom % 4), 1 + int'($urandom % 20),
            16'($urandom), 16'($urandom));
      end
      for (int k = 0; k < 16; k++) begin
        set_req(4'($urandom));
        repeat (25) @(posedge clk);
      end
      set_req(4'b0000);
      wait_idle();
      for (int c = 0; c < NCH; c++) begin
        chk(int'(type_o[3*c +: 3]) == m_type[c], "R1 stored code", type_o[3*c +: 3], m_type[c]);
        chk(err_o[c] == (m_type[c] >= 3), "R9 error flag", err_o[c], m_type[c] >= 3);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule